// File: doc/BRIEF.md
# Two-Phase Clock-Enable Generator

This block derives two single-cycle clock-enable pulses, a phase-one enable and a phase-two enable, from one fast system clock. A synchronous CPU core that runs on the fast clock treats each pulse as one edge of a slower nominal CPU clock. The core then keeps its original two-phase timing without dual-edge flip-flops or transparent latches. The two enables strictly alternate and never overlap. Together they mark out one nominal period.

A programmable divide setting `s` gives a nominal period of 2(s+1) fast cycles. The phase-two pulse falls halfway through that period. With `s = 0` the fast clock runs at exactly twice the nominal clock, and the two enables land on consecutive fast cycles. The generator sits outside the CPU core. A free-running phase counter and a strobe on the last cycle of each nominal period let the rest of the system line its own timing up with the CPU phases. A new divide setting takes effect only at a period boundary.

Top module: `twophase_cken`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge, the next cycle shows `ph1_en`, `ph2_en` and `period_end` low and `phase_cnt` equal to 0.
- R2: Reset may be released on any cycle. The first enable after release is always `ph1_en`. It is high in the cycle that follows the first rising edge at which `rst_n` is sampled high.
- R3: While running, `ph1_en` is high exactly when `phase_cnt` is 0, and `ph2_en` is high exactly when `phase_cnt` equals H, where H = s+1 for the setting `s` in force. Each pulse lasts one fast cycle.
- R4: `ph1_en` and `ph2_en` are never high in the same cycle.
- R5: The enables strictly alternate. Every `ph2_en` is preceded by a `ph1_en` with no other enable between them, and two `ph1_en` pulses always have exactly one `ph2_en` between them.
- R6: With setting `s`, consecutive `ph1_en` pulses are 2(s+1) fast cycles apart, and `ph2_en` follows `ph1_en` by s+1 cycles. With `s = 0` the two enables fall on consecutive cycles.
- R7: While running, `phase_cnt` counts up by one each cycle from 0 to 2H-1 and then returns to 0.
- R8: `period_end` is high exactly in the cycle where `phase_cnt` equals 2H-1, so it is always the cycle immediately before a `ph1_en` pulse.
- R9: `div_sel` is sampled only on a rising edge during reset or on the rising edge that ends a period (`period_end` high). A change at any other time has no effect on the period in progress.
- R10: Asserting reset in the middle of a period abandons that period. After release, timing restarts from R2 with no leftover pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_sel | input | DIV_W | Divide setting s; nominal period is 2(s+1) fast cycles |
| ph1_en | output | 1 | Phase-one clock enable, one fast cycle wide |
| ph2_en | output | 1 | Phase-two clock enable, one fast cycle wide |
| period_end | output | 1 | High on the last fast cycle of each nominal period |
| phase_cnt | output | DIV_W+1 | Position inside the current nominal period |

## Verification
The bench targets the exact-2x setting. A design with an off-by-one half period there would space the phases unevenly or make the two enables collide. It also changes `div_sel` on every cycle in the middle of a period. A design that did not hold the setting would cut a pulse short or emit a doubled one. It releases and reasserts reset at arbitrary points inside a period. A design that resumed from a stale count, or that led with phase two, would break alternation. Long random runs compare every output against a bench reference model on every cycle.

// File: rtl/twophase_cken_pkg.sv
// Package: shared types for the two-phase clock-enable generator.
// Assumes: consumers size the counter as DIV_W+1 bits.
package twophase_cken_pkg;

    // Bundle of decoded single-cycle strobes produced each fast cycle.
    typedef struct packed {
        logic ph1;
        logic ph2;
        logic pend;
    } cken_strobes_t;

endpackage

// File: rtl/twophase_ratio_latch.sv
// Module: twophase_ratio_latch
// Holds the divide setting in force for the current nominal period and
// derives the half-period and last-count values from it.
// Assumes: load is high during reset and on the edge that ends a period.
module twophase_ratio_latch #(
    parameter int DIV_W = 4,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [DIV_W-1:0] div_sel,
    output logic [CNT_W-1:0] half_cnt,
    output logic [CNT_W-1:0] last_cnt
);

    logic [DIV_W-1:0] sel_q;

    // Capture the setting in reset and at each period boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= div_sel;
        end else if (wrap) begin
            sel_q <= div_sel;
        end
    end

    // Half period is s+1; the last count 2(s+1)-1 equals 2s+1.
    always_comb begin
        half_cnt = {1'b0, sel_q} + CNT_W'(1);
        last_cnt = {sel_q, 1'b1};
    end

endmodule

// File: rtl/twophase_phase_ctr.sv
// Module: twophase_phase_ctr
// Free-running phase counter with a run flag that is set one cycle after
// reset release, so the first running cycle always starts at count 0.
// Assumes: last_cnt is stable for the whole period (see ratio latch).
module twophase_phase_ctr #(
    parameter int DIV_W = 4,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             run,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt
);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    // Period ends when the running count reaches the last value.
    assign wrap = run_q && (cnt_q == last_cnt);

    // Hold count at zero in reset; step or wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= 1'b1;
            if (wrap) begin
                cnt_q <= '0;
            end else if (run_q) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign run = run_q;
    assign cnt = cnt_q;

endmodule

// File: rtl/twophase_pulse_dec.sv
// Module: twophase_pulse_dec
// Decodes the phase counter into phase-one, phase-two and period-end strobes.
// Assumes: half_cnt lies in 1..last_cnt, so the strobes fall on distinct counts
// except that phase two and period end coincide at the 2x setting.
module twophase_pulse_dec
    import twophase_cken_pkg::*;
#(
    parameter int DIV_W = 4,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] half_cnt,
    input  logic [CNT_W-1:0] last_cnt,
    output cken_strobes_t    strobes
);

    // Compare the count against the fixed positions inside the period.
    always_comb begin
        strobes.ph1  = run && (cnt == '0);
        strobes.ph2  = run && (cnt == half_cnt);
        strobes.pend = run && (cnt == last_cnt);
    end

endmodule

// File: rtl/twophase_cken.sv
// Module: twophase_cken (top)
// Generates alternating single-cycle phase enables for a CPU core that runs
// on the fast clock. Nominal period is 2(div_sel+1) fast cycles.
// Assumes: synchronous active-low reset that may be released on any cycle.
module twophase_cken
    import twophase_cken_pkg::*;
#(
    parameter int DIV_W = 4,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             ph1_en,
    output logic             ph2_en,
    output logic             period_end,
    output logic [CNT_W-1:0] phase_cnt
);

    logic             run;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_cnt;
    logic [CNT_W-1:0] last_cnt;
    cken_strobes_t    strobes;

    twophase_ratio_latch #(.DIV_W(DIV_W)) u_ratio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .div_sel  (div_sel),
        .half_cnt (half_cnt),
        .last_cnt (last_cnt)
    );

    twophase_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_cnt (last_cnt),
        .run      (run),
        .wrap     (wrap),
        .cnt      (cnt)
    );

    twophase_pulse_dec #(.DIV_W(DIV_W)) u_dec (
        .run      (run),
        .cnt      (cnt),
        .half_cnt (half_cnt),
        .last_cnt (last_cnt),
        .strobes  (strobes)
    );

    // Drive the ports from the decoded strobes and the counter.
    assign ph1_en     = strobes.ph1;
    assign ph2_en     = strobes.ph2;
    assign period_end = strobes.pend;
    assign phase_cnt  = cnt;

endmodule

// File: rtl/twophase_cken_chk.sv
// Module: twophase_cken_chk
// Port-level checker for twophase_cken, attached with bind below.
// Assumes: observes only the top-level ports.
module twophase_cken_chk #(
    parameter int DIV_W = 4,
    localparam int CNT_W = DIV_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_sel,
    input logic             ph1_en,
    input logic             ph2_en,
    input logic             period_end,
    input logic [CNT_W-1:0] phase_cnt
);

    logic [DIV_W-1:0] sel_seen;
    logic [1:0]       last_kind;  // 0 none, 1 phase one, 2 phase two

    // Track the setting the checker expects in force, from the ports alone.
    always_ff @(posedge clk) begin
        if (!rst_n || period_end) begin
            sel_seen <= div_sel;
        end
    end

    // Track which enable was seen most recently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_kind <= 2'd0;
        end else if (ph1_en) begin
            last_kind <= 2'd1;
        end else if (ph2_en) begin
            last_kind <= 2'd2;
        end
    end

    // R1: reset quiets every output on the following cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!ph1_en && !ph2_en && !period_end && phase_cnt == '0));

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph1_en && ph2_en));

    p_ph1_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ph1_en |-> (phase_cnt == '0));

    p_ph2_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ph2_en |-> (phase_cnt == {1'b0, sel_seen} + CNT_W'(1)));

    p_alt_ph2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ph2_en |-> (last_kind == 2'd1));

    p_alt_ph1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ph1_en |-> (last_kind != 2'd1));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (ph1_en && phase_cnt == '0));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt != '0 && !period_end) |=> (phase_cnt == $past(phase_cnt) + CNT_W'(1)));

endmodule

bind twophase_cken twophase_cken_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_sel    (div_sel),
    .ph1_en     (ph1_en),
    .ph2_en     (ph2_en),
    .period_end (period_end),
    .phase_cnt  (phase_cnt)
);

// File: tb/twophase_cken_bench.sv
// Bench for twophase_cken: directed corners plus seeded random stimulus,
// compared every cycle against a reference model built from the requirements.
module twophase_cken_bench;

    localparam int DIV_W = 4;
    localparam int CNT_W = DIV_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_sel = '0;
    logic             ph1_en, ph2_en, period_end;
    logic [CNT_W-1:0] phase_cnt;

    twophase_cken #(.DIV_W(DIV_W)) u_twophase_cken (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_sel    (div_sel),
        .ph1_en     (ph1_en),
        .ph2_en     (ph2_en),
        .period_end (period_end),
        .phase_cnt  (phase_cnt)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    // Reference model state
    bit m_run  = 1'b0;
    bit m_prev_run = 1'b0;
    int m_cnt  = 0;
    int m_half = 1;

    // Alternation and spacing trackers
    int last_kind = 0;
    int ph1_cyc = 0;
    int ph1_half = 0;
    bit have_ph1 = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int last_of(input int h);
        return 2 * h - 1;
    endfunction

    // Compare outputs (settled after the last rising edge) to the model.
    task automatic compare_now();
        bit e1, e2, ep;
        e1 = m_run && (m_cnt == 0);
        e2 = m_run && (m_cnt == m_half);
        ep = m_run && (m_cnt == last_of(m_half));
        if (!m_run) begin
            chk(!ph1_en && !ph2_en && !period_end && phase_cnt == 0, "R1",
                "reset outputs", {ph1_en, ph2_en, period_end, phase_cnt}, 0);
            last_kind = 0;
            have_ph1  = 1'b0;
        end else begin
            chk(ph1_en == e1, "R3", "ph1_en", ph1_en, e1);
            chk(ph2_en == e2, "R3 R9", "ph2_en", ph2_en, e2);
            chk(period_end == ep, "R8", "period_end", period_end, ep);
            chk(int'(phase_cnt) == m_cnt, "R7", "phase_cnt", phase_cnt, m_cnt);
            chk(!(ph1_en && ph2_en), "R4", "overlap", ph1_en & ph2_en, 0);
            if (!m_prev_run)
                chk(ph1_en && !ph2_en, "R2", "first enable after release", ph1_en, 1);
            if (ph1_en) begin
                chk(last_kind != 1, "R5", "ph1 twice", last_kind, 2);
                if (have_ph1)
                    chk(cyc - ph1_cyc == 2 * ph1_half, "R6", "ph1 spacing",
                        cyc - ph1_cyc, 2 * ph1_half);
                last_kind = 1;
                ph1_cyc   = cyc;
                ph1_half  = m_half;
                have_ph1  = 1'b1;
            end
            if (ph2_en) begin
                chk(last_kind == 1, "R5", "ph2 without ph1", last_kind, 1);
                chk(cyc - ph1_cyc == m_half, "R6", "ph1 to ph2 gap",
                    cyc - ph1_cyc, m_half);
                last_kind = 2;
            end
        end
        m_prev_run = m_run;
    endtask

    // Advance the model as the coming rising edge will.
    task automatic model_step(input bit r, input int s);
        if (!r) begin
            m_run = 1'b0; m_cnt = 0; m_half = s + 1;
        end else if (!m_run) begin
            m_run = 1'b1;
        end else if (m_cnt == last_of(m_half)) begin
            m_cnt = 0; m_half = s + 1;
        end else begin
            m_cnt++;
        end
    endtask

    task automatic tick(input bit r, input int s);
        @(negedge clk);
        cyc++;
        compare_now();
        rst_n   = r;
        div_sel = DIV_W'(s);
        model_step(r, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_step(1'b0, 0);
        @(posedge clk);
        // R6: exact 2x setting, enables on consecutive cycles
        repeat (3) tick(1'b0, 0);
        repeat (16) tick(1'b1, 0);
        // R9: setting changes every cycle while periods run
        repeat (2) tick(1'b0, 5);
        for (int i = 0; i < 60; i++) tick(1'b1, int'($urandom % 16));
        // R10: reset in the middle of a period, then restart
        repeat (2) tick(1'b0, 2);
        repeat (4) tick(1'b1, 2);
        tick(1'b0, 7);
        repeat (25) tick(1'b1, 1);
        // R2: release reset after a one-cycle pulse at the widest setting
        tick(1'b0, 15);
        repeat (70) tick(1'b1, 15);
        // Random mix of settings and resets
        for (int i = 0; i < 4000; i++) begin
            bit r;
            int s;
            r = ($urandom % 150) != 0;
            s = ($urandom % 8 == 0) ? int'($urandom % 16) : int'(div_sel);
            tick(r, s);
        end
        tick(1'b1, int'(div_sel));
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

endmodule